// File: doc/BRIEF.md
# Toggle-Handshake Signed Divider

This block divides one 32-bit signed operand by another for a generated datapath. The controller does not send a start pulse. It asks for a division by making its request bit `u_en` differ from the divider's acknowledge bit `en`. On the next clock edge the divider copies `u_en` into `en` and raises `done`. On the edge after that it writes the signed quotient and remainder of the operands present in that cycle into `q` and `r`, and drops `done`.

Each cycle exactly one of three behaviours applies: idle, accept or produce. The controller must keep `a` and `b` steady from the request until `done` falls, because the operands are sampled when the result is written. Division truncates toward zero, and the remainder carries the sign of the dividend. Both awkward operand pairs give defined results and raise no trap. If the request bit changes again while `done` is high, the request is held. It is taken on the cycle after `done` returns to zero.

Top module: `tsd_divider`

## Requirements
- R1: When `rst_n` is low at a rising edge, that edge clears `en`, `done`, `q` and `r` to zero.
- R2: With `done` = 0 and `en` = `u_en` (idle), an edge leaves `en`, `done`, `q` and `r` unchanged, whatever `a` and `b` are.
- R3: With `done` = 0 and `en` ≠ `u_en` (accept), the next edge sets `en` to the sampled `u_en` and sets `done` to 1, leaving `q` and `r` unchanged.
- R4: With `done` = 1 (produce), the next edge loads `q` and `r` from the `a` and `b` of that cycle, clears `done` and leaves `en` unchanged. `done` is therefore high for exactly one cycle, and the result is visible two edges after the request was first sampled.
- R5: For `b` ≠ 0 the quotient truncates toward zero, and `q*b + r` equals `a` modulo 2^32.
- R6: For `b` ≠ 0 the remainder is zero or has the sign of `a`, and |`r`| < |`b`|.
- R7: Division by zero gives `q` = 0 and `r` = `a`.
- R8: The most negative dividend (0x80000000) divided by -1 gives `q` = 0x80000000 and `r` = 0.
- R9: A change of `u_en` made while `done` = 1 is not lost. `done` rises again on the edge after the one that clears it, and the new result appears on the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a | input | 32 | Signed dividend |
| b | input | 32 | Signed divisor |
| u_en | input | 1 | Request bit; a request is pending while it differs from `en` |
| q | output | 32 | Signed quotient, registered |
| r | output | 32 | Signed remainder, registered |
| en | output | 1 | Acknowledge bit, a copy of `u_en` taken at accept |
| done | output | 1 | High during the one cycle between accept and produce |

## Verification
The hardest case to reach from the ports is a new request arriving while `done` is high. That request must survive the produce edge and be taken one cycle later, with fresh operands. The stimulus flips `u_en` in the middle of a transaction. It then changes the operands only after `done` has fallen, and checks that `done` comes back on the expected edge with the second result. Random operands are biased toward small and zero divisors and toward extreme dividends. Directed cases add division by zero, the overflowing quotient and all four sign combinations.

// File: rtl/tsd_pkg.sv
// Shared definitions for the toggle-handshake signed divider.
// Assumes two's-complement operands of a common width.
package tsd_pkg;

    // Behaviour chosen for the current cycle; exactly one applies.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACCEPT  = 2'd1,
        PH_PRODUCE = 2'd2
    } tsd_phase_e;

endpackage

// File: rtl/tsd_handshake.sv
// Request/acknowledge sequencer. A request is pending while u_en differs
// from the acknowledge bit. Accepting it copies u_en and raises the busy
// flag; the next cycle is the produce cycle, which drops the flag.
// Assumes u_en is synchronous to clk.
module tsd_handshake
    import tsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       u_en,
    output logic       ack,
    output logic       busy,
    output tsd_phase_e phase
);

    // Decode which of the three behaviours applies this cycle.
    always_comb begin
        if (busy) begin
            phase = PH_PRODUCE;
        end else if (ack != u_en) begin
            phase = PH_ACCEPT;
        end else begin
            phase = PH_IDLE;
        end
    end

    // Update the acknowledge bit and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            busy <= 1'b0;
        end else begin
            case (phase)
                PH_ACCEPT: begin
                    ack  <= u_en;
                    busy <= 1'b1;
                end
                PH_PRODUCE: begin
                    busy <= 1'b0;
                end
                default: begin
                    ack  <= ack;
                    busy <= busy;
                end
            endcase
        end
    end

endmodule

// File: rtl/tsd_divcore.sv
// Combinational signed divider. It divides the operand magnitudes with an
// unrolled restoring array, one stage per quotient bit, and then restores
// the signs: the quotient truncates toward zero and the remainder follows
// the dividend. A zero divisor yields quotient 0 and remainder equal to the
// dividend. MIN / -1 wraps to MIN with remainder 0.
// Assumes the caller registers the outputs; there is no internal state.
module tsd_divcore #(
    parameter int W = 32
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    localparam int DW = W + 2;

    logic           num_neg;
    logic           den_neg;
    logic           den_zero;
    logic [W-1:0]   num_mag;
    logic [W-1:0]   den_mag;
    logic [W-1:0]   mag_q;
    logic [W:0][W-1:0] part;

    // Split the operands into sign and magnitude.
    always_comb begin
        num_neg  = dividend[W-1];
        den_neg  = divisor[W-1];
        den_zero = (divisor == '0);
        num_mag  = num_neg ? (~dividend + 1'b1) : dividend;
        den_mag  = den_neg ? (~divisor + 1'b1) : divisor;
    end

    assign part[0] = '0;

    // One restoring stage per quotient bit, most significant bit first.
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0]    trial;
        logic [DW-1:0] diff;

        assign trial = {part[i], num_mag[W-1-i]};
        assign diff  = {1'b0, trial} - {2'b00, den_mag};

        // Keep the difference when it is non-negative, else restore.
        always_comb begin
            if (!diff[DW-1]) begin
                part[i+1]      = diff[W-1:0];
                mag_q[W-1-i]   = 1'b1;
            end else begin
                part[i+1]      = trial[W-1:0];
                mag_q[W-1-i]   = 1'b0;
            end
        end
    end

    // Restore the signs and apply the zero-divisor rule.
    always_comb begin
        if (den_zero) begin
            quot = '0;
            rem  = dividend;
        end else begin
            quot = (num_neg ^ den_neg) ? (~mag_q + 1'b1) : mag_q;
            rem  = num_neg ? (~part[W] + 1'b1) : part[W];
        end
    end

endmodule

// File: rtl/tsd_result.sv
// Result registers. They load the quotient and remainder only in the
// produce cycle and hold them otherwise.
// Assumes the phase decode comes from the handshake sequencer.
module tsd_result
    import tsd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  tsd_phase_e phase,
    input  logic [W-1:0] quot_in,
    input  logic [W-1:0] rem_in,
    output logic [W-1:0] quot_q,
    output logic [W-1:0] rem_q
);

    // Capture the result in the produce cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
        end else if (phase == PH_PRODUCE) begin
            quot_q <= quot_in;
            rem_q  <= rem_in;
        end
    end

endmodule

// File: rtl/tsd_divider.sv
// Top level of the toggle-handshake signed divider: the sequencer, the
// combinational divider and the result registers.
// Assumes a and b are held stable from the request until done falls.
module tsd_divider
    import tsd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         u_en,
    output logic [W-1:0] q,
    output logic [W-1:0] r,
    output logic         en,
    output logic         done
);

    tsd_phase_e   phase;
    logic [W-1:0] core_q;
    logic [W-1:0] core_r;

    tsd_handshake u_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .u_en  (u_en),
        .ack   (en),
        .busy  (done),
        .phase (phase)
    );

    tsd_divcore #(.W(W)) u_core (
        .dividend (a),
        .divisor  (b),
        .quot     (core_q),
        .rem      (core_r)
    );

    tsd_result #(.W(W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .quot_in (core_q),
        .rem_in  (core_r),
        .quot_q  (q),
        .rem_q   (r)
    );

endmodule

// File: rtl/tsd_checker.sv
// Temporal checks on the divider's ports, bound into every instance.
module tsd_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         u_en,
    input logic [W-1:0] q,
    input logic [W-1:0] r,
    input logic         en,
    input logic         done
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    function automatic logic [W:0] mag(input logic [W-1:0] v);
        return v[W-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (en == 1'b0 && done == 1'b0 && q == '0 && r == '0));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && en == u_en) |=> (!done && $stable(en) && $stable(q) && $stable(r)));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && en != u_en) |=> (done && en == $past(u_en) && $stable(q) && $stable(r)));

    assert_produce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && $stable(en)));

    assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b != '0) |=> (q * $past(b) + r == $past(a)));

    assert_rem_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b != '0) |=> ((r == '0 || r[W-1] == $past(a[W-1])) && mag(r) < mag($past(b))));

    assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b == '0) |=> (q == '0 && r == $past(a)));

    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && a == MOST_NEG && b == '1) |=> (q == MOST_NEG && r == '0));

endmodule

bind tsd_divider tsd_checker #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .u_en  (u_en),
    .q     (q),
    .r     (r),
    .en    (en),
    .done  (done)
);

// File: tb/tsd_divider_tb.sv
`timescale 1ns/1ps
module tsd_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        u_en_i = 1'b0;
    logic [31:0] q_o;
    logic [31:0] r_o;
    logic        en_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed_sink;

    always #2.5 clk = ~clk;

    tsd_divider u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a_i),
        .b     (b_i),
        .u_en  (u_en_i),
        .q     (q_o),
        .r     (r_o),
        .en    (en_o),
        .done  (done_o)
    );

    // Reference: quotient in the upper half, remainder in the lower half.
    function automatic logic [63:0] ref_div(input logic [31:0] x, input logic [31:0] y);
        longint lx, ly, lq, lr;
        if (y == 32'd0) return {32'd0, x};
        lx = longint'($signed(x));
        ly = longint'($signed(y));
        lq = lx / ly;
        lr = lx % ly;
        return {lq[31:0], lr[31:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Full transaction; called at a negative edge.
    task automatic run_div(input logic [31:0] x, input logic [31:0] y, input string tag);
        logic [31:0] q_before, r_before;
        logic [63:0] e;
        q_before = q_o;
        r_before = r_o;
        e = ref_div(x, y);
        a_i = x;
        b_i = y;
        u_en_i = ~u_en_i;
        @(posedge clk); @(negedge clk);
        chk("R3 accept done/en", {62'd0, done_o, en_o}, {62'd0, 1'b1, u_en_i});
        chk("R3 accept keeps q,r", {q_o, r_o}, {q_before, r_before});
        @(posedge clk); @(negedge clk);
        chk("R4 done falls", {63'd0, done_o}, 64'd0);
        chk(tag, {q_o, r_o}, e);
    endtask

    task automatic idle_cycles(input int n);
        logic [63:0] held;
        held = {q_o, r_o};
        for (int k = 0; k < n; k++) begin
            a_i = $urandom;
            b_i = $urandom;
            @(posedge clk); @(negedge clk);
            chk("R2 idle holds q,r", {q_o, r_o}, held);
            chk("R2 idle holds done,en", {62'd0, done_o, en_o}, {62'd0, 1'b0, u_en_i});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] x, y;
        logic [63:0] e;
        seed_sink = $urandom(32'd20240517);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {q_o, r_o}, 64'd0);
        chk("R1 reset flags", {62'd0, done_o, en_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_cycles(3);

        run_div(32'd100, 32'd7, "R5 100/7");
        run_div(-32'sd100, 32'd7, "R6 -100/7");
        run_div(32'd100, -32'sd7, "R5 100/-7");
        run_div(-32'sd100, -32'sd7, "R6 -100/-7");
        run_div(32'h1234_5678, 32'd0, "R7 divide by zero");
        run_div(32'h8000_0000, 32'd0, "R7 MIN by zero");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, "R8 MIN / -1");
        run_div(32'h8000_0000, 32'd1, "R5 MIN / 1");
        run_div(32'd5, 32'h8000_0000, "R6 5 / MIN");
        run_div(32'h7FFF_FFFF, 32'h8000_0000, "R6 MAX / MIN");
        idle_cycles(2);

        // A second request made while done is high must be held.
        x = 32'hFFFF_F000;
        y = 32'd3;
        a_i = 32'd999;
        b_i = 32'd10;
        u_en_i = ~u_en_i;
        @(posedge clk); @(negedge clk);
        chk("R9 first accept", {63'd0, done_o}, 64'd1);
        u_en_i = ~u_en_i;
        @(posedge clk); @(negedge clk);
        chk("R9 first result", {q_o, r_o}, ref_div(32'd999, 32'd10));
        chk("R9 done low after produce", {63'd0, done_o}, 64'd0);
        a_i = x;
        b_i = y;
        @(posedge clk); @(negedge clk);
        chk("R9 pending accepted", {62'd0, done_o, en_o}, {62'd0, 1'b1, u_en_i});
        @(posedge clk); @(negedge clk);
        chk("R9 second result", {q_o, r_o}, ref_div(x, y));
        idle_cycles(1);

        for (int it = 0; it < 300; it++) begin
            x = $urandom;
            y = $urandom;
            case ($urandom % 6)
                0: y = $urandom % 9 - 4;
                1: x = ($urandom % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
                2: y = {{16{y[15]}}, y[15:0]};
                default: ;
            endcase
            run_div(x, y, (y == 0) ? "R7 random zero divisor" : "R5 R6 random");
            if (it % 50 == 0) idle_cycles(1);
        end

        // Reset in the middle of a result clears everything.
        run_div(32'd77, 32'd5, "R5 before reset");
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 reset clears result", {q_o, r_o}, 64'd0);
        chk("R1 reset clears flags", {62'd0, done_o, en_o}, 64'd0);
        rst_n = 1'b1;
        u_en_i = 1'b0;
        @(negedge clk);
        e = ref_div(-32'sd77, 32'd5);
        run_div(-32'sd77, 32'd5, "R6 after reset");
        chk("R6 after reset value", {q_o, r_o}, e);
        finish_run();
    end

endmodule